// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Serial Readout

This block is the digital controller of a small 10-bit successive-approximation converter. A conversion-start pin wakes it from shutdown. The pulse pattern on that pin chooses the input routing: a plain rising edge picks the primary selection, and a short high-low-high pattern picks the alternate one. In the two-channel single-ended build, primary is channel 1 and alternate is channel 2. In the one-channel differential build, primary is unipolar and alternate is bipolar. The block tracks while the start pin is high and holds at its falling edge. It then runs a binary search against an external comparator decision, drives the trial code to the DAC, and falls back to shutdown when the search is done.

The result is read out by a host-driven serial clock as a 12-bit frame: the 10 result bits MSB first, then two sub-bits that are always zero. The data pin changes on serial-clock falling edges and is released after the last rising edge. If the host rises the start pin again before the whole frame has been read, the next conversion uses the alternate selection. Both pins are synchronized into a fast system clock. The conversion clock is a division of that system clock.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset the block is in shutdown: `track_o`, `hold_o`, `sel_alt_o` and `dout_en_o` are all low.
- R2: A rising edge on `start_i` in shutdown raises `track_o` and enables the data output driving low (`dout_en_o`=1, `dout_o`=0).
- R3: While tracking, if `start_i` falls and rises again within GAP_CYC system cycles of the detected fall, `sel_alt_o` goes to 1 and tracking resumes.
- R4: A fall of `start_i` during tracking lowers `track_o` and raises `hold_o`. If no rise follows within the GAP_CYC window, the conversion starts.
- R5: The conversion tests one bit per CONV_DIV system cycles, from the MSB down. Each bit is kept when `cmp_i`=1 (input at or above `dac_code_o`) and cleared otherwise. The search result equals the largest code not above the input. Afterwards `hold_o` and `track_o` are both low.
- R6: When the conversion finishes, `dout_o` presents the result MSB with `dout_en_o` high.
- R7: Each falling edge of `sclk_i` after the first rising edge moves `dout_o` to the next frame bit. The order is result bit 9 down to bit 0, then two sub-bits that are both 0.
- R8: The 12th rising edge of `sclk_i` drives `dout_en_o` low, and further `sclk_i` edges leave it low.
- R9: In the differential build (DIFF_VARIANT=1), the primary selection gives straight binary. The alternate selection gives two's complement, which is the search result with its MSB inverted.
- R10: In the single-ended build (DIFF_VARIANT=0), the alternate selection still gives straight binary.
- R11: If fewer than 12 rising `sclk_i` edges followed the last conversion when `start_i` rises from shutdown, `sel_alt_o` is 1 for the new conversion, whatever the pulse pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the conversion clock is derived from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion start / selection pulse pin (asynchronous) |
| sclk_i | input | 1 | Host serial clock (asynchronous) |
| cmp_i | input | 1 | Comparator decision: 1 when input is at or above the DAC trial code |
| dac_code_o | output | RES_BITS | Trial code driven to the DAC |
| track_o | output | 1 | Track phase active |
| hold_o | output | 1 | Hold phase active (sampling window and conversion) |
| sel_alt_o | output | 1 | Alternate selection: channel 2 or bipolar mode |
| dout_o | output | 1 | Serial data value |
| dout_en_o | output | 1 | Serial data output enable; low means high impedance |

## Verification
The assertions assume that `start_i` and `sclk_i` change slowly compared with `clk`. Every high or low phase must last longer than the synchronizer latency, so that each pin edge yields exactly one detected edge. They also assume that the host keeps `sclk_i` low while idle, so that a frame always begins with a rising edge. The stimulus holds each pin level for at least eight system cycles, keeps the double-pulse gap at three cycles (inside the eight-cycle window), and leaves `sclk_i` low except while reading. The comparator is modelled as a threshold on a model input code, so every response is consistent with a single input value.

// File: rtl/sarctl_pkg.sv
package sarctl_pkg;
  typedef enum logic [1:0] {
    SQ_SHDN  = 2'd0,
    SQ_TRACK = 2'd1,
    SQ_PEND  = 2'd2,
    SQ_CONV  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/sarctl_sync_edge.sv
module sarctl_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], pin_i};
  end

  assign rise_o = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
  assign fall_o = ~pipe_q[SYNC_STAGES-1] & pipe_q[SYNC_STAGES];
endmodule

// File: rtl/sarctl_seq.sv
module sarctl_seq
  import sarctl_pkg::*;
#(
  parameter int GAP_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_rise_i,
  input  logic start_fall_i,
  input  logic frame_clear_i,
  input  logic conv_done_i,
  output logic wake_o,
  output logic conv_go_o,
  output logic track_o,
  output logic hold_o,
  output logic sel_alt_o
);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

  seq_state_t state_q;
  logic [GW-1:0] gap_q;
  logic alt_q;

  assign wake_o    = (state_q == SQ_SHDN) && start_rise_i;
  assign conv_go_o = (state_q == SQ_PEND) && !start_rise_i && (gap_q == GAP_LAST);
  assign track_o   = (state_q == SQ_TRACK);
  assign hold_o    = (state_q == SQ_PEND) || (state_q == SQ_CONV);
  assign sel_alt_o = alt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_SHDN;
      gap_q   <= '0;
      alt_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_SHDN: if (start_rise_i) begin
          state_q <= SQ_TRACK;
          alt_q   <= !frame_clear_i;
        end
        SQ_TRACK: if (start_fall_i) begin
          state_q <= SQ_PEND;
          gap_q   <= '0;
        end
        SQ_PEND: begin
          if (start_rise_i) begin
            state_q <= SQ_TRACK;
            alt_q   <= 1'b1;
          end else if (gap_q == GAP_LAST) begin
            state_q <= SQ_CONV;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        SQ_CONV: if (conv_done_i) state_q <= SQ_SHDN;
        default: state_q <= SQ_SHDN;
      endcase
    end
  end

  // R11
  forced_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && !frame_clear_i) |=> sel_alt_o);
  // R3
  double_pulse_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_PEND && start_rise_i) |=> (sel_alt_o && track_o));
  // R4
  fall_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (track_o && start_fall_i) |=> (hold_o && !track_o));
endmodule

// File: rtl/sarctl_sar.sv
module sarctl_sar #(
  parameter int RES_BITS = 10,
  parameter int CONV_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                done_o
);
  localparam int DW = (CONV_DIV > 1) ? $clog2(CONV_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CONV_DIV - 1);
  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [DW-1:0]       div_q;
  logic [RES_BITS-1:0] trial_q, code_q, result_q;
  logic                busy_q, done_q;
  logic                step;
  logic [RES_BITS-1:0] kept, next_code;

  assign step      = busy_q && (div_q == DIV_LAST);
  assign kept      = cmp_i ? code_q : (code_q & ~trial_q);
  assign next_code = kept | (trial_q >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; trial_q <= '0; code_q <= '0; result_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        busy_q  <= 1'b1;
        trial_q <= TOP_BIT;
        code_q  <= TOP_BIT;
        div_q   <= '0;
      end else if (step) begin
        div_q   <= '0;
        code_q  <= next_code;
        trial_q <= trial_q >> 1;
        if (trial_q[0]) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= kept;
        end
      end else if (busy_q) begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign dac_code_o = code_q;
  assign result_o   = result_q;
  assign done_o     = done_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5
  trial_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ($countones(trial_q) == 1));
endmodule

// File: rtl/sarctl_shift.sv
module sarctl_shift #(
  parameter int RES_BITS = 10,
  parameter int SUB_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wake_i,
  input  logic                load_i,
  input  logic [RES_BITS-1:0] data_i,
  input  logic                sclk_rise_i,
  input  logic                sclk_fall_i,
  output logic                dout_o,
  output logic                dout_en_o,
  output logic                frame_clear_o
);
  localparam int FRAME = RES_BITS + SUB_BITS;
  localparam int CW = $clog2(FRAME + 1);
  localparam logic [CW-1:0] LAST_RD = CW'(FRAME - 1);

  logic [FRAME-1:0] sh_q;
  logic [CW-1:0]    rd_q;
  logic             active_q, en_q, unread_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; rd_q <= '0; active_q <= 1'b0; en_q <= 1'b0; unread_q <= 1'b0;
    end else if (wake_i) begin
      sh_q <= '0; rd_q <= '0; active_q <= 1'b0; en_q <= 1'b1; unread_q <= 1'b0;
    end else if (load_i) begin
      sh_q     <= {data_i, {SUB_BITS{1'b0}}};
      rd_q     <= '0;
      active_q <= 1'b1;
      unread_q <= 1'b1;
    end else if (active_q) begin
      if (sclk_rise_i) begin
        rd_q <= rd_q + 1'b1;
        if (rd_q == LAST_RD) begin
          en_q     <= 1'b0;
          active_q <= 1'b0;
          unread_q <= 1'b0;
        end
      end else if (sclk_fall_i && rd_q != '0) begin
        sh_q <= {sh_q[FRAME-2:0], 1'b0};
      end
    end
  end

  assign dout_o        = sh_q[FRAME-1];
  assign dout_en_o     = en_q;
  assign frame_clear_o = !unread_q;

  // R8
  release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && sclk_rise_i && rd_q == LAST_RD && !wake_i) |=> !dout_en_o);
  // R7
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_i && !load_i && !sclk_fall_i) |=> $stable(dout_o));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int DIFF_VARIANT = 1,
  parameter int RES_BITS     = 10,
  parameter int SUB_BITS     = 2,
  parameter int CONV_DIV     = 4,
  parameter int GAP_CYC      = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                sclk_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic                track_o,
  output logic                hold_o,
  output logic                sel_alt_o,
  output logic                dout_o,
  output logic                dout_en_o
);
  function automatic logic [RES_BITS-1:0] to_twos(input logic [RES_BITS-1:0] raw);
    return {~raw[RES_BITS-1], raw[RES_BITS-2:0]};
  endfunction

  logic st_rise, st_fall, sc_rise, sc_fall;
  logic wake, conv_go, conv_done, frame_clear;
  logic [RES_BITS-1:0] raw_result, coded_result;

  sarctl_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_start_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(start_i), .rise_o(st_rise), .fall_o(st_fall));

  sarctl_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(sclk_i), .rise_o(sc_rise), .fall_o(sc_fall));

  sarctl_seq #(.GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_rise_i(st_rise), .start_fall_i(st_fall),
    .frame_clear_i(frame_clear), .conv_done_i(conv_done), .wake_o(wake),
    .conv_go_o(conv_go), .track_o(track_o), .hold_o(hold_o), .sel_alt_o(sel_alt_o));

  sarctl_sar #(.RES_BITS(RES_BITS), .CONV_DIV(CONV_DIV)) u_sar (
    .clk(clk), .rst_n(rst_n), .go_i(conv_go), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .result_o(raw_result), .done_o(conv_done));

  generate
    if (DIFF_VARIANT != 0) begin : g_diff
      assign coded_result = sel_alt_o ? to_twos(raw_result) : raw_result;
    end else begin : g_single
      assign coded_result = raw_result;
    end
  endgenerate

  sarctl_shift #(.RES_BITS(RES_BITS), .SUB_BITS(SUB_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .wake_i(wake), .load_i(conv_done),
    .data_i(coded_result), .sclk_rise_i(sc_rise), .sclk_fall_i(sc_fall),
    .dout_o(dout_o), .dout_en_o(dout_en_o), .frame_clear_o(frame_clear));

  // R2
  wake_drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (dout_en_o && !dout_o && track_o));
  // R6
  msb_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (dout_en_o && dout_o == coded_result[RES_BITS-1] && !hold_o && !track_o));
endmodule

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sclk = 1'b0;
  int vin_d = 0;
  int vin_s = 0;
  logic cmp_d, cmp_s;
  logic [NB-1:0] dac_d, dac_s;
  logic trk_d, hld_d, alt_d, do_d, en_d;
  logic trk_s, hld_s, alt_s, do_s, en_s;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp_d = (vin_d >= int'(dac_d));
  assign cmp_s = (vin_s >= int'(dac_s));

  sar_conv_ctrl #(.DIFF_VARIANT(1)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sclk_i(sclk), .cmp_i(cmp_d),
    .dac_code_o(dac_d), .track_o(trk_d), .hold_o(hld_d), .sel_alt_o(alt_d),
    .dout_o(do_d), .dout_en_o(en_d));

  sar_conv_ctrl #(.DIFF_VARIANT(0)) dut_se (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sclk_i(sclk), .cmp_i(cmp_s),
    .dac_code_o(dac_s), .track_o(trk_s), .hold_o(hld_s), .sel_alt_o(alt_s),
    .dout_o(do_s), .dout_en_o(en_s));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] frame_of(input int v, input bit twos);
    logic [NB-1:0] r;
    r = NB'(v);
    if (twos) r[NB-1] = ~r[NB-1];
    return {r, 2'b00};
  endfunction

  task automatic t_reset();
    cyc(3);
    chk("R1 reset track/hold/alt/en", {28'd0, trk_d, hld_d, alt_d, en_d}, 32'd0);
    chk("R1 reset se", {28'd0, trk_s, hld_s, alt_s, en_s}, 32'd0);
  endtask

  // Wake, optional double pulse, hold, conversion, then read nread bits.
  task automatic t_conv(input string name, input bit dbl, input int vd, input int vs,
                        input bit exp_alt, input int nread);
    logic [11:0] fd, fs;
    logic [11:0] gd, gs;
    vin_d = vd; vin_s = vs;
    fd = frame_of(vd, exp_alt);
    fs = frame_of(vs, 1'b0);
    gd = '0; gs = '0;
    start = 1'b1; cyc(20);
    chk({"R2 track/en/dout ", name}, {29'd0, trk_d, en_d, do_d}, {29'd0, 3'b110});
    chk({"R2 se track/en/dout ", name}, {29'd0, trk_s, en_s, do_s}, {29'd0, 3'b110});
    if (dbl) begin
      start = 1'b0; cyc(3);
      start = 1'b1; cyc(20);
      chk({"R3 alt after double pulse ", name}, {30'd0, alt_d, alt_s}, 32'd3);
      chk({"R3 tracking resumed ", name}, {30'd0, trk_d, hld_d}, 32'd2);
    end else begin
      chk({"R11 selection on wake ", name}, {30'd0, alt_d, alt_s}, {30'd0, exp_alt, exp_alt});
    end
    start = 1'b0; cyc(6);
    chk({"R4 hold after fall ", name}, {30'd0, trk_d, hld_d}, 32'd1);
    cyc(100);
    chk({"R5 back to shutdown ", name}, {28'd0, trk_d, hld_d, trk_s, hld_s}, 32'd0);
    chk({"R6 msb presented ", name}, {30'd0, en_d, do_d}, {30'd0, 1'b1, fd[11]});
    chk({"R6 se msb presented ", name}, {30'd0, en_s, do_s}, {30'd0, 1'b1, fs[11]});
    for (int k = 0; k < nread; k++) begin
      gd[11-k] = do_d; gs[11-k] = do_s;
      sclk = 1'b1; cyc(8);
      sclk = 1'b0; cyc(8);
    end
    if (nread == 12) begin
      chk({"R7 R9 frame diff ", name}, {20'd0, gd}, {20'd0, fd});
      chk({"R7 R10 frame se ", name}, {20'd0, gs}, {20'd0, fs});
      chk({"R8 released after 12 ", name}, {30'd0, en_d, en_s}, 32'd0);
      sclk = 1'b1; cyc(8); sclk = 1'b0; cyc(8);
      chk({"R8 stays released ", name}, {30'd0, en_d, en_s}, 32'd0);
    end else begin
      chk({"R7 partial read diff ", name}, {20'd0, gd >> (12 - nread)},
          {20'd0, fd >> (12 - nread)});
      chk({"R7 still enabled mid-frame ", name}, {31'd0, en_d}, 32'd1);
    end
    cyc(10);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    t_reset();
    // R9 unipolar straight binary
    t_conv("uni", 1'b0, 'h2C5, 'h2C5, 1'b0, 12);
    // R9 bipolar two's complement; R10 single-ended channel 2 stays binary
    t_conv("bip", 1'b1, 'h0A3, 'h0A3, 1'b1, 12);
    // R5 full-scale boundary
    t_conv("full", 1'b0, 'h3FF, 'h3FF, 1'b0, 12);
    // R5 zero boundary, frame left unread
    t_conv("zero_partial", 1'b0, 0, 0, 1'b0, 5);
    // R11 single pulse forced to alternate selection
    t_conv("forced", 1'b0, 'h155, 'h155, 1'b1, 12);
    // R11 completed frame returns to primary selection; midscale boundary
    t_conv("mid", 1'b0, 'h200, 'h1FF, 1'b0, 12);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R5 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule